// File: doc/BRIEF.md
# Per-Cycle Regulation Error Monitor

The block watches the current regulation loop one sample at a time. For each accepted pair of a current reference and a measured current it forms the error (reference minus measurement) and takes its magnitude. It compares that magnitude with two programmable limits. The warning flag reports the most recent sample only. The fault flag is latched, because a regulation fault has to stop the converter and must stay visible until it is cleared.

Over each machine cycle the block also tracks the largest error magnitude. When the next cycle starts, that peak is handed out on a valid/ready output stream as a quality figure for the cycle just ended, and tracking restarts. The sample input never stalls: `s_ready` is tied high, so samples arriving at 10 kHz are always taken.

On the output stream an item stays valid and unchanged until `m_ready` is high. If a new cycle boundary arrives while an item is still pending, the pending item is replaced by the newer peak, and there is never more than one item outstanding.

Top module: `regerr_monitor`

## Requirements
- R1: The error is `s_ref - s_meas` on signed W-bit values (W=24). Its magnitude saturates at 2^(W-1)-1 = 0x7FFFFF instead of wrapping, whatever the sign of the error.
- R2: On each accepted sample (`s_valid` high), `warn` is updated one clock later to (magnitude > `warn_lim`). It holds that value until the next sample.
- R3: `fault` is set one clock after a sample whose magnitude > `flt_lim`. It then stays set until `flt_clr` is high. When a tripping sample and `flt_clr` arrive in the same clock, the fault stays set.
- R4: Both comparisons are strictly greater-than: a magnitude equal to a limit trips neither flag.
- R5: The running peak is the largest magnitude of the samples accepted since the last `cyc_start`. On `cyc_start` that peak is published and the running peak is cleared. A sample accepted in the same clock as `cyc_start` belongs to the new cycle.
- R6: `m_valid` goes high in the clock after `cyc_start`, with `m_peak` carrying the published peak. Both hold steady until a clock in which `m_ready` is high.
- R7: A `cyc_start` while an item is still pending replaces `m_peak` with the newer peak and keeps `m_valid` high. Only one item is ever outstanding.
- R8: `s_ready` is always high: the sample input is never back-pressured.
- R9: After reset, `warn`, `fault` and `m_valid` are low and the running peak is 0. A cycle with no samples therefore publishes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample accepted (always 1) |
| s_ref | input | W | Signed current reference |
| s_meas | input | W | Signed measured current |
| cyc_start | input | 1 | One-clock machine cycle boundary pulse |
| warn_lim | input | W | Warning limit, unsigned magnitude |
| flt_lim | input | W | Fault limit, unsigned magnitude |
| flt_clr | input | 1 | Clears the latched fault |
| warn | output | 1 | Last sample exceeded the warning limit |
| fault | output | 1 | Latched fault-limit excursion |
| m_valid | output | 1 | Published peak available |
| m_ready | input | 1 | Consumer takes the published peak |
| m_peak | output | W | Peak error magnitude of the previous cycle |

## Verification
The bench aims at the saturation edge with errors of both signs that overflow 24 bits. A design that wraps would report a tiny or negative-looking magnitude there. It drives magnitudes exactly equal to each limit, where an off-by-one comparison would raise a flag. It hits the same-clock cases: a sample coinciding with a cycle start, which must open the new peak rather than join the published one, and a fault trip coinciding with its clear, which must leave the fault set. It also holds `m_ready` low across two cycle boundaries, so a design that drops the newer peak or lets the output drift is caught by the scoreboard.

// File: rtl/regerr_pkg.sv
package regerr_pkg;
  localparam int unsigned DEF_W = 24;

  // Largest magnitude representable as a positive W-bit signed value.
  function automatic longint unsigned sat_max(input int unsigned w);
    return (longint'(1) << (w - 1)) - 1;
  endfunction
endpackage

// File: rtl/regerr_mag.sv
module regerr_mag #(
  parameter int unsigned W = regerr_pkg::DEF_W
) (
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] meas_i,
  output logic        [W-1:0] mag_o
);
  localparam logic [W:0] SAT = (W+1)'(regerr_pkg::sat_max(W));

  logic signed [W:0] diff;
  logic        [W:0] absd;

  always_comb begin
    diff = $signed({ref_i[W-1], ref_i}) - $signed({meas_i[W-1], meas_i});
    absd = diff[W] ? (~diff + 1'b1) : diff;
    if (absd > SAT) mag_o = SAT[W-1:0];
    else            mag_o = absd[W-1:0];
  end
endmodule

// File: rtl/regerr_thresh.sv
module regerr_thresh #(
  parameter int unsigned W       = regerr_pkg::DEF_W,
  parameter bit          LATCHED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] mag,
  input  logic [W-1:0] lim,
  input  logic         clr,
  output logic         flag
);
  logic over;
  assign over = upd && (mag > lim);

  generate
    if (LATCHED) begin : g_latched
      always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (over) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
      end
    end else begin : g_follow
      always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (clr)  flag <= 1'b0;
        else if (upd)  flag <= over;
      end
    end
  endgenerate
endmodule

// File: rtl/regerr_peak.sv
module regerr_peak #(
  parameter int unsigned W = regerr_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] mag,
  input  logic         start,
  output logic [W-1:0] run_peak
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    run_peak <= '0;
    else if (start)                run_peak <= upd ? mag : '0;
    else if (upd && mag > run_peak) run_peak <= mag;
  end
endmodule

// File: rtl/regerr_pub.sv
module regerr_pub #(
  parameter int unsigned W = regerr_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] din,
  input  logic         m_ready,
  output logic         m_valid,
  output logic [W-1:0] m_peak
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_peak  <= '0;
    end else if (start) begin
      m_valid <= 1'b1;
      m_peak  <= din;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/regerr_monitor.sv
module regerr_monitor #(
  parameter int unsigned W = regerr_pkg::DEF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic signed [W-1:0] s_ref,
  input  logic signed [W-1:0] s_meas,
  input  logic                cyc_start,
  input  logic        [W-1:0] warn_lim,
  input  logic        [W-1:0] flt_lim,
  input  logic                flt_clr,
  output logic                warn,
  output logic                fault,
  output logic                m_valid,
  input  logic                m_ready,
  output logic        [W-1:0] m_peak
);
  logic [W-1:0] mag;
  logic [W-1:0] run_peak;
  logic         take;

  assign s_ready = 1'b1;
  assign take    = s_valid && s_ready;

  regerr_mag #(.W(W)) u_mag (
    .ref_i(s_ref), .meas_i(s_meas), .mag_o(mag)
  );

  regerr_thresh #(.W(W), .LATCHED(1'b0)) u_warn (
    .clk(clk), .rst_n(rst_n), .upd(take), .mag(mag),
    .lim(warn_lim), .clr(1'b0), .flag(warn)
  );

  regerr_thresh #(.W(W), .LATCHED(1'b1)) u_fault (
    .clk(clk), .rst_n(rst_n), .upd(take), .mag(mag),
    .lim(flt_lim), .clr(flt_clr), .flag(fault)
  );

  regerr_peak #(.W(W)) u_peak (
    .clk(clk), .rst_n(rst_n), .upd(take), .mag(mag),
    .start(cyc_start), .run_peak(run_peak)
  );

  regerr_pub #(.W(W)) u_pub (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .din(run_peak),
    .m_ready(m_ready), .m_valid(m_valid), .m_peak(m_peak)
  );
endmodule

// File: rtl/regerr_monitor_chk.sv
module regerr_monitor_chk #(
  parameter int unsigned W = regerr_pkg::DEF_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic         cyc_start,
  input logic         flt_clr,
  input logic         warn,
  input logic         fault,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_peak
);
  AST_WARN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> $stable(warn)); // R2

  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    fault && !flt_clr |=> fault); // R3

  AST_FAULT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid && !fault |=> !fault); // R3

  AST_PUBLISH_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> m_valid); // R6

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !cyc_start |=> m_valid && $stable(m_peak)); // R6

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid && !cyc_start |=> !m_valid); // R7

  AST_INPUT_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready); // R8
endmodule

bind regerr_monitor regerr_monitor_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .cyc_start(cyc_start), .flt_clr(flt_clr), .warn(warn), .fault(fault),
  .m_valid(m_valid), .m_ready(m_ready), .m_peak(m_peak)
);

// File: tb/regerr_monitor_tb.sv
module regerr_monitor_tb;
  localparam int W = 24;
  localparam longint SATV = (longint'(1) << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic signed [W-1:0] s_ref = '0, s_meas = '0;
  logic cyc_start = 1'b0;
  logic [W-1:0] warn_lim = '0, flt_lim = '0;
  logic flt_clr = 1'b0;
  logic warn, fault, m_valid;
  logic m_ready = 1'b1;
  logic [W-1:0] m_peak;

  int checks = 0;
  int errors = 0;
  longint model_peak = 0;
  logic exp_warn = 1'b0, exp_fault = 1'b0;
  logic [W-1:0] expq[$];

  always #10 clk = ~clk;

  regerr_monitor #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_ref(s_ref), .s_meas(s_meas), .cyc_start(cyc_start),
    .warn_lim(warn_lim), .flt_lim(flt_lim), .flt_clr(flt_clr),
    .warn(warn), .fault(fault), .m_valid(m_valid), .m_ready(m_ready),
    .m_peak(m_peak)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint emag(input longint r, input longint m);
    longint d = r - m;
    if (d < 0) d = -d;
    if (d > SATV) d = SATV;
    return d;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic model_sample(input longint r, input longint m, input bit clr);
    longint g = emag(r, m);
    exp_warn = (g > longint'(warn_lim));
    if (g > longint'(flt_lim)) exp_fault = 1'b1;
    else if (clr)              exp_fault = 1'b0;
    if (g > model_peak) model_peak = g;
  endtask

  task automatic check_flags(input string tag);
    chk(warn == exp_warn, {tag, " warn R2"}, warn, exp_warn);
    chk(fault == exp_fault, {tag, " fault R3"}, fault, exp_fault);
    chk(s_ready == 1'b1, "s_ready R8", s_ready, 1);
  endtask

  task automatic send(input longint r, input longint m, input bit clr, input string tag);
    s_valid = 1'b1; s_ref = W'(r); s_meas = W'(m); flt_clr = clr;
    model_sample(r, m, clr);
    step();
    s_valid = 1'b0; flt_clr = 1'b0;
    check_flags(tag);
  endtask

  // Cycle boundary; optional sample in the same clock; replace models R7 overwrite
  task automatic cycle(input bit with_s, input longint r, input longint m, input bit replace);
    if (replace) void'(expq.pop_back());
    expq.push_back(W'(model_peak));
    model_peak = 0;
    cyc_start = 1'b1;
    s_valid = with_s; s_ref = W'(r); s_meas = W'(m);
    if (with_s) model_sample(r, m, 1'b0);
    step();
    cyc_start = 1'b0; s_valid = 1'b0;
    chk(m_valid == 1'b1, "m_valid after cyc_start R6", m_valid, 1);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "unexpected output R6", m_peak, -1);
      end else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        chk(m_peak == e, "published peak R5", m_peak, e);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk(warn == 0, "reset warn R9", warn, 0);
    chk(fault == 0, "reset fault R9", fault, 0);
    chk(m_valid == 0, "reset m_valid R9", m_valid, 0);
    chk(s_ready == 1, "reset s_ready R8", s_ready, 1);

    warn_lim = 1000; flt_lim = 5000;
    // R2/R4 warning behaviour
    send(500, 100, 0, "small");
    send(2000, 500, 0, "over warn");
    step(); step();
    chk(warn == 1, "warn held while idle R2", warn, 1);
    send(0, 1000, 0, "equal warn R4");
    chk(warn == 0, "equal to limit no warn R4", warn, 0);
    send(-300, 0, 0, "negative small");

    // R5 publish 1500; then empty cycle publishes 0 (R9)
    cycle(0, 0, 0, 0);
    step();
    cycle(0, 0, 0, 0);
    step();

    // R1 saturation both signs, also trips fault R3
    send(SATV, -1, 0, "sat pos R1");
    send(-(SATV + 1), 1, 0, "sat neg R1");
    send(10, 0, 0, "fault holds R3");
    chk(fault == 1, "fault latched R3", fault, 1);
    send(10, 0, 1, "clear R3");
    chk(fault == 0, "fault cleared R3", fault, 0);
    send(5000, 0, 0, "equal fault R4");
    chk(fault == 0, "equal to fault limit R4", fault, 0);
    send(0, 6000, 1, "trip with clear R3");
    chk(fault == 1, "trip wins over clear R3", fault, 1);
    send(0, 0, 1, "clear again R3");
    cycle(0, 0, 0, 0); // publishes 0x7FFFFF R1
    step();

    // R5 same-clock sample begins new cycle
    send(300, 0, 0, "pre");
    cycle(1, 0, 700, 0); // publishes 300, new peak 700
    step();
    send(50, 0, 0, "post");
    cycle(0, 0, 0, 0);   // publishes 700
    step();

    // R7 back-pressure
    m_ready = 1'b0;
    send(111, 0, 0, "bp a");
    cycle(0, 0, 0, 0);   // pending 111
    send(222, 0, 0, "bp b");
    step();
    chk(m_valid == 1 && m_peak == 111, "held under back-pressure R6", m_peak, 111);
    cycle(0, 0, 0, 1);   // replaces with 222
    chk(m_peak == 222, "newest replaces pending R7", m_peak, 222);
    step();
    m_ready = 1'b1;
    step(); step();
    chk(m_valid == 0, "single item drained R7", m_valid, 0);
    chk(expq.size() == 0, "scoreboard empty R7", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule